// File: doc/BRIEF.md
# Converter Register Initialization Sequencer

This block brings a high-speed data converter into a known, calibrated state after power-up by driving a simple SPI master through a fixed list of register accesses. A `start` pulse issues a soft reset write. The block then polls the converter's initialization flag, and only after that flag is set does it apply the configuration. The configuration first takes down the serial link and then the calibration engine. It writes the mode, frame-size, sync/format, overrange and driver-emphasis settings, then brings calibration back up before the link. Finally it pulses the calibration trigger low and then high.

After the trigger, the sequencer polls the calibration status until the foreground run reports completion. It then polls the link status until the serial PLL reports lock, and raises `done`. Each of the three waits has its own cycle-count timeout. When a wait times out, the sequencer stops in an error state with a code that names the wait that failed. It stays there until the next `start`. The SPI serializer, clock-chip setup and the link receiver sit outside this block.

Top module: `cnv_init_seq`

## Requirements
- R1: After synchronous reset, `cmd_valid`, `done` and `err` are 0, `err_code` is 0 and `state` is 0 (idle).
- R2: Each command is a 24-bit `cmd_frame`: bit 23 is read/write (1 = read), bits 22:8 are the register address and bits 7:0 are the write data (0 for reads). A read's result arrives on `rsp_data` together with `rsp_valid`. Once raised, `cmd_valid` stays high with `cmd_frame` unchanged until `cmd_ready` is sampled high. Only one command is outstanding at a time.
- R3: The first command after `start` writes 0xB0 to address 0x0000 (soft reset).
- R4: After the reset write, the block reads address 0x0270 repeatedly and issues no write until a response has bit 0 set.
- R5: The first two configuration writes are 0x00 to 0x0200 (link enable off), then 0x00 to 0x0061 (calibration enable off).
- R6: Next come the writes 0x0201 = `MODE_VAL`, 0x0202 = `KM1_VAL`, 0x0204 = `SYNC_VAL`, 0x0213 = 0x07 and 0x0048 = 0x03, in that order.
- R7: Next come the writes 0x0061 = 0x01, then 0x0200 = 0x01, then 0x006C = 0x00, then 0x006C = 0x01.
- R8: After the trigger, the block reads 0x006A repeatedly until a response has bit `CAL_DONE_BIT` (default 1) set.
- R9: The block then reads 0x0208 repeatedly until a response has bit 2 set. It then raises `done`, and the command stream stops.
- R10: If a poll response has the awaited bit clear after the timer for that wait has reached its limit, the block raises `err` and sets `err_code` (1 = init, 2 = calibration, 3 = PLL lock). It issues no further commands and holds both outputs until `start`.
- R11: `start` has no effect while a sequence is running. In the done or error state, `start` clears `done`, `err` and `err_code` and begins a new sequence.
- R12: `state` encodes 0 idle, 1 reset write, 2 init poll, 3 configuration, 4 calibration poll, 5 PLL poll, 6 done, 7 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (idle, done or error only) |
| cmd_valid | output | 1 | Command frame offered to the SPI master |
| cmd_ready | input | 1 | SPI master accepts the frame |
| cmd_frame | output | 24 | {rw, address[14:0], data[7:0]} |
| rsp_valid | input | 1 | Transaction completed |
| rsp_data | input | 8 | Read data of the completed transaction |
| done | output | 1 | Sequence completed with calibration done and PLL locked |
| err | output | 1 | A wait timed out |
| err_code | output | 2 | Failed wait: 1 init, 2 calibration, 3 PLL |
| state | output | 3 | Sequencer phase |

## Verification
On every cycle, the assertions check the command handshake (a frame held stable until accepted), that done and error never appear together, that a reported error carries a non-zero code and stays latched, that the finished states stay silent on the command port, and that the timeout flag does not drop between clears. Only the bench scenarios show the exact order of writes, the enable ordering, the low-then-high trigger, and that each poll watches the right address and bit. The same holds for which wait an error is charged to and for a start pulse being ignored mid-sequence. The bench shows these by comparing the full logged command stream against a stream it builds itself.

// File: rtl/cnv_init_pkg.sv
package cnv_init_pkg;

  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 15;
  localparam int DATA_W  = 8;
  localparam int TBL_N   = 12;
  localparam int IDX_W   = $clog2(TBL_N);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RSTWR = 3'd1,
    ST_INIT  = 3'd2,
    ST_CFG   = 3'd3,
    ST_CAL   = 3'd4,
    ST_PLL   = 3'd5,
    ST_DONE  = 3'd6,
    ST_ERR   = 3'd7
  } seq_state_e;

  localparam logic [1:0] EC_NONE = 2'd0;
  localparam logic [1:0] EC_INIT = 2'd1;
  localparam logic [1:0] EC_CAL  = 2'd2;
  localparam logic [1:0] EC_PLL  = 2'd3;

  localparam logic [ADDR_W-1:0] A_SOFT_RST  = 15'h0000;
  localparam logic [ADDR_W-1:0] A_PREEMPH   = 15'h0048;
  localparam logic [ADDR_W-1:0] A_CAL_ENA   = 15'h0061;
  localparam logic [ADDR_W-1:0] A_CAL_STAT  = 15'h006A;
  localparam logic [ADDR_W-1:0] A_CAL_TRIG  = 15'h006C;
  localparam logic [ADDR_W-1:0] A_LINK_ENA  = 15'h0200;
  localparam logic [ADDR_W-1:0] A_MODE      = 15'h0201;
  localparam logic [ADDR_W-1:0] A_KM1       = 15'h0202;
  localparam logic [ADDR_W-1:0] A_SYNC_FMT  = 15'h0204;
  localparam logic [ADDR_W-1:0] A_LINK_STAT = 15'h0208;
  localparam logic [ADDR_W-1:0] A_OVR_CTL   = 15'h0213;
  localparam logic [ADDR_W-1:0] A_INIT_STAT = 15'h0270;

  localparam int PLL_LOCK_BIT  = 2;
  localparam int INIT_DONE_BIT = 0;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_entry_t;

  function automatic logic [FRAME_W-1:0] mk_frame(input logic rd,
                                                  input logic [ADDR_W-1:0] a,
                                                  input logic [DATA_W-1:0] d);
    return {rd, a, d};
  endfunction

endpackage

// File: rtl/cnv_init_rom.sv
module cnv_init_rom
  import cnv_init_pkg::*;
#(
  parameter logic [7:0] MODE_VAL = 8'h00,
  parameter logic [7:0] KM1_VAL  = 8'h03,
  parameter logic [7:0] SYNC_VAL = 8'h01
) (
  input  logic [IDX_W-1:0] idx,
  output wr_entry_t        entry
);

  // Index order is behaviour: disables, settings, enables, trigger low/high.
  always_comb begin
    case (idx)
      4'd0:    entry = '{A_SOFT_RST, 8'hB0};
      4'd1:    entry = '{A_LINK_ENA, 8'h00};
      4'd2:    entry = '{A_CAL_ENA,  8'h00};
      4'd3:    entry = '{A_MODE,     MODE_VAL};
      4'd4:    entry = '{A_KM1,      KM1_VAL};
      4'd5:    entry = '{A_SYNC_FMT, SYNC_VAL};
      4'd6:    entry = '{A_OVR_CTL,  8'h07};
      4'd7:    entry = '{A_PREEMPH,  8'h03};
      4'd8:    entry = '{A_CAL_ENA,  8'h01};
      4'd9:    entry = '{A_LINK_ENA, 8'h01};
      4'd10:   entry = '{A_CAL_TRIG, 8'h00};
      4'd11:   entry = '{A_CAL_TRIG, 8'h01};
      default: entry = '{A_SOFT_RST, 8'h00};
    endcase
  end

endmodule

// File: rtl/cnv_poll_timer.sv
module cnv_poll_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (cnt_q < limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= limit);

  AST_TMR_STICKY: assert property (@(posedge clk) disable iff (rst) (expired && !clr && $stable(limit)) |=> expired) else $error("timer flag dropped"); // R10

endmodule

// File: rtl/cnv_init_seq.sv
module cnv_init_seq
  import cnv_init_pkg::*;
#(
  parameter logic [7:0]  MODE_VAL     = 8'h00,
  parameter logic [7:0]  KM1_VAL      = 8'h03,
  parameter logic [7:0]  SYNC_VAL     = 8'h01,
  parameter int unsigned INIT_TMO     = 200_000_000,
  parameter int unsigned CAL_TMO      = 200_000_000,
  parameter int unsigned PLL_TMO      = 2_000_000,
  parameter int          CAL_DONE_BIT = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [23:0] cmd_frame,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_data,
  output logic        done,
  output logic        err,
  output logic [1:0]  err_code,
  output logic [2:0]  state
);

  localparam int unsigned TMO_MAX0 = (INIT_TMO > CAL_TMO) ? INIT_TMO : CAL_TMO;
  localparam int unsigned TMO_MAX  = (TMO_MAX0 > PLL_TMO) ? TMO_MAX0 : PLL_TMO;
  localparam int          TMO_W    = $clog2(TMO_MAX + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_N - 1);

  seq_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q;
  logic               cmd_valid_q;
  logic [FRAME_W-1:0] cmd_frame_q;
  logic               done_q;
  logic               err_q;
  logic [1:0]         err_code_q;
  logic               tmr_clr_q;
  logic               tmr_exp;
  logic [TMO_W-1:0]   tmr_limit;
  wr_entry_t          rom_entry;
  logic [FRAME_W-1:0] next_frame;

  cnv_init_rom #(
    .MODE_VAL (MODE_VAL),
    .KM1_VAL  (KM1_VAL),
    .SYNC_VAL (SYNC_VAL)
  ) rom_i (
    .idx   (idx_q),
    .entry (rom_entry)
  );

  always_comb begin
    case (state_q)
      ST_CAL:  tmr_limit = TMO_W'(CAL_TMO);
      ST_PLL:  tmr_limit = TMO_W'(PLL_TMO);
      default: tmr_limit = TMO_W'(INIT_TMO);
    endcase
  end

  cnv_poll_timer #(.W(TMO_W)) tmr_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr_q),
    .limit   (tmr_limit),
    .expired (tmr_exp)
  );

  always_comb begin
    case (state_q)
      ST_INIT: next_frame = mk_frame(1'b1, A_INIT_STAT, 8'h00);
      ST_CAL:  next_frame = mk_frame(1'b1, A_CAL_STAT,  8'h00);
      ST_PLL:  next_frame = mk_frame(1'b1, A_LINK_STAT, 8'h00);
      default: next_frame = mk_frame(1'b0, rom_entry.addr, rom_entry.data);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      busy_q      <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_frame_q <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      err_code_q  <= EC_NONE;
      tmr_clr_q   <= 1'b1;
    end else begin
      tmr_clr_q <= 1'b0;
      case (state_q)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start) begin
            state_q    <= ST_RSTWR;
            idx_q      <= '0;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            err_code_q <= EC_NONE;
            tmr_clr_q  <= 1'b1;
          end
        end
        default: begin
          if (!busy_q) begin
            cmd_valid_q <= 1'b1;
            cmd_frame_q <= next_frame;
            busy_q      <= 1'b1;
          end else if (cmd_valid_q) begin
            if (cmd_ready) cmd_valid_q <= 1'b0;
          end else if (rsp_valid) begin
            busy_q <= 1'b0;
            case (state_q)
              ST_RSTWR: begin
                state_q   <= ST_INIT;
                idx_q     <= IDX_W'(1);
                tmr_clr_q <= 1'b1;
              end
              ST_INIT: begin
                if (rsp_data[INIT_DONE_BIT]) begin
                  state_q <= ST_CFG;
                end else if (tmr_exp) begin
                  state_q    <= ST_ERR;
                  err_q      <= 1'b1;
                  err_code_q <= EC_INIT;
                end
              end
              ST_CFG: begin
                if (idx_q == LAST_IDX) begin
                  state_q   <= ST_CAL;
                  tmr_clr_q <= 1'b1;
                end else begin
                  idx_q <= idx_q + 1'b1;
                end
              end
              ST_CAL: begin
                if (rsp_data[CAL_DONE_BIT]) begin
                  state_q   <= ST_PLL;
                  tmr_clr_q <= 1'b1;
                end else if (tmr_exp) begin
                  state_q    <= ST_ERR;
                  err_q      <= 1'b1;
                  err_code_q <= EC_CAL;
                end
              end
              ST_PLL: begin
                if (rsp_data[PLL_LOCK_BIT]) begin
                  state_q <= ST_DONE;
                  done_q  <= 1'b1;
                end else if (tmr_exp) begin
                  state_q    <= ST_ERR;
                  err_q      <= 1'b1;
                  err_code_q <= EC_PLL;
                end
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign cmd_valid = cmd_valid_q;
  assign cmd_frame = cmd_frame_q;
  assign done      = done_q;
  assign err       = err_q;
  assign err_code  = err_code_q;
  assign state     = state_q;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst) (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_frame))) else $error("frame dropped before accept"); // R2
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(done && err)) else $error("done with err"); // R10
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (rst) err |-> (err_code != EC_NONE)) else $error("err without code"); // R10
  AST_ERR_LATCHED: assert property (@(posedge clk) disable iff (rst) (err && !start) |=> (err && $stable(err_code))) else $error("err not held"); // R10
  AST_DONE_LATCHED: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> done) else $error("done not held"); // R9
  AST_END_QUIET: assert property (@(posedge clk) disable iff (rst) (done || err) |-> !cmd_valid) else $error("command after end"); // R9
  AST_DONE_STATE: assert property (@(posedge clk) disable iff (rst) done |-> (state == 3'd6)) else $error("done state code"); // R12

endmodule

// File: tb/cnv_init_seq_tb_top.sv
`timescale 1ns/1ps
module cnv_init_seq_tb_top;

  localparam logic [7:0] P_MODE = 8'h00;
  localparam logic [7:0] P_KM1  = 8'h03;
  localparam logic [7:0] P_SYNC = 8'h01;
  localparam int         P_TMO  = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [23:0] cmd_frame;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'h00;
  logic        done;
  logic        err;
  logic [1:0]  err_code;
  logic [2:0]  state;

  int checks = 0;
  int errors = 0;
  int init_need, cal_need, pll_need;
  int init_cnt, cal_cnt, pll_cnt;
  logic [23:0] log_q[$];
  logic [23:0] exp_q[$];

  always #2.5 clk = ~clk;

  cnv_init_seq #(
    .MODE_VAL (P_MODE), .KM1_VAL (P_KM1), .SYNC_VAL (P_SYNC),
    .INIT_TMO (P_TMO), .CAL_TMO (P_TMO), .PLL_TMO (P_TMO), .CAL_DONE_BIT (1)
  ) dut_i (
    .clk (clk), .rst (rst), .start (start),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_frame (cmd_frame),
    .rsp_valid (rsp_valid), .rsp_data (rsp_data),
    .done (done), .err (err), .err_code (err_code), .state (state)
  );

  function automatic logic [23:0] fr(input logic rd, input logic [14:0] a, input logic [7:0] d);
    return {rd, a, d};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Status model: returns random data with the watched bit forced.
  task automatic model_rsp(input logic [23:0] f, output logic [7:0] d);
    logic [7:0] r;
    r = 8'($urandom);
    d = r;
    if (f[23]) begin
      case (f[22:8])
        15'h0270: begin d = (init_need >= 0 && init_cnt >= init_need) ? (r | 8'h01) : (r & 8'hFE); init_cnt++; end
        15'h006A: begin d = (cal_need  >= 0 && cal_cnt  >= cal_need)  ? (r | 8'h02) : (r & 8'hFD); cal_cnt++;  end
        15'h0208: begin d = (pll_need  >= 0 && pll_cnt  >= pll_need)  ? (r | 8'h04) : (r & 8'hFB); pll_cnt++;  end
        default: ;
      endcase
    end
  endtask

  // SPI master model
  initial begin
    logic [23:0] f;
    logic [7:0]  d;
    forever begin
      @(negedge clk);
      if (cmd_valid === 1'b1 && !rst) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        f = cmd_frame;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        log_q.push_back(f);
        model_rsp(f, d);
        repeat ($urandom_range(0, 4)) @(negedge clk);
        rsp_data  = d;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  // fail: 0 none, 1 init, 2 cal, 3 pll
  task automatic build_exp(input int ni, input int nc, input int np, input int fail);
    exp_q.delete();
    exp_q.push_back(fr(0, 15'h0000, 8'hB0));
    if (fail == 1) return;
    repeat (ni + 1) exp_q.push_back(fr(1, 15'h0270, 8'h00));
    exp_q.push_back(fr(0, 15'h0200, 8'h00));
    exp_q.push_back(fr(0, 15'h0061, 8'h00));
    exp_q.push_back(fr(0, 15'h0201, P_MODE));
    exp_q.push_back(fr(0, 15'h0202, P_KM1));
    exp_q.push_back(fr(0, 15'h0204, P_SYNC));
    exp_q.push_back(fr(0, 15'h0213, 8'h07));
    exp_q.push_back(fr(0, 15'h0048, 8'h03));
    exp_q.push_back(fr(0, 15'h0061, 8'h01));
    exp_q.push_back(fr(0, 15'h0200, 8'h01));
    exp_q.push_back(fr(0, 15'h006C, 8'h00));
    exp_q.push_back(fr(0, 15'h006C, 8'h01));
    if (fail == 2) return;
    repeat (nc + 1) exp_q.push_back(fr(1, 15'h006A, 8'h00));
    if (fail == 3) return;
    repeat (np + 1) exp_q.push_back(fr(1, 15'h0208, 8'h00));
  endtask

  function automatic string req_of(input int i, input int ni);
    if (i == 0) return "R3";
    if (i <= ni + 1) return "R4";
    if (i <= ni + 3) return "R5";
    if (i <= ni + 8) return "R6";
    if (i <= ni + 12) return "R7";
    return "R8";
  endfunction

  task automatic run(input int ni, input int nc, input int np, input int fail, input bit mid_start);
    int n;
    int mism;
    int first_bad;
    logic [23:0] poll_fr;
    init_need = (fail == 1) ? -1 : ni;
    cal_need  = (fail == 2) ? -1 : nc;
    pll_need  = (fail == 3) ? -1 : np;
    init_cnt = 0; cal_cnt = 0; pll_cnt = 0;
    log_q.delete();
    build_exp(ni, nc, np, fail);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(state == 3'd1, "R12", "state after start", state, 1);
    chk(!done && !err && err_code == 2'd0, "R11", "flags cleared by start", {done, err, err_code}, 0);
    n = 0;
    while (!(done || err)) begin
      @(negedge clk);
      n++;
      if (mid_start && n == 40 && !(done || err)) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    repeat (30) @(negedge clk);
    // Prefix compare
    mism = 0; first_bad = -1;
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i >= log_q.size() || log_q[i] !== exp_q[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    end
    if (first_bad >= 0)
      chk(0, req_of(first_bad, ni), "command stream",
          (first_bad < log_q.size()) ? int'(log_q[first_bad]) : -1, int'(exp_q[first_bad]));
    else
      chk(1, mid_start ? "R11" : "R2", "command stream", 0, 0);
    if (fail == 0) begin
      chk(log_q.size() == exp_q.size(), "R9", "stream length", log_q.size(), exp_q.size());
      chk(done && !err, "R9", "done raised", {done, err}, 2'b10);
      chk(state == 3'd6, "R12", "done state", state, 6);
    end else begin
      poll_fr = (fail == 1) ? fr(1, 15'h0270, 8'h00) : (fail == 2) ? fr(1, 15'h006A, 8'h00) : fr(1, 15'h0208, 8'h00);
      chk(log_q.size() > exp_q.size(), "R10", "polls before timeout", log_q.size(), exp_q.size() + 1);
      mism = 0;
      for (int i = exp_q.size(); i < log_q.size(); i++)
        if (log_q[i] !== poll_fr) mism++;
      chk(mism == 0, (fail == 1) ? "R4" : (fail == 2) ? "R8" : "R9", "poll frames after prefix", mism, 0);
      chk(err && !done && err_code == 2'(fail), "R10", "error code", {err, done, err_code}, {2'b10, 2'(fail)});
      chk(state == 3'd7, "R12", "error state", state, 7);
      n = log_q.size();
      repeat (40) @(negedge clk);
      chk(log_q.size() == n && !cmd_valid, "R10", "silent after error", log_q.size(), n);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!cmd_valid && !done && !err && err_code == 2'd0 && state == 3'd0, "R1", "reset outputs",
        {cmd_valid, done, err, err_code, state}, 0);
    repeat (10) @(negedge clk);
    chk(log_q.size() == 0, "R1", "no command without start", log_q.size(), 0);
    // Directed corners
    run(0, 0, 0, 0, 0);
    run(3, 2, 1, 0, 1);     // R11 start ignored mid-run
    run(0, 0, 0, 1, 0);     // R10 init timeout
    run(2, 1, 0, 2, 0);     // R10 calibration timeout
    run(1, 3, 2, 3, 0);     // R10 PLL timeout
    // Random mix
    for (int k = 0; k < 8; k++) begin
      int f;
      f = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
      run($urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6), f, bit'($urandom_range(0, 1)));
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule